// File: doc/BRIEF.md
# Unsigned 8x8 multiply execution unit

This unit carries out one instruction of a small 8-bit processor core: an unsigned multiply of two registers. It contains the core's 32 x 8-bit register file and its 8-bit status register. When a 16-bit instruction word is offered with a valid strobe, the unit checks the word against the multiply pattern. On a match it pulls the two source register numbers out of the word and reads both operands. It writes the 16-bit unsigned product into registers 0 (low byte) and 1 (high byte), and updates the carry and zero flags. A word that does not match raises an illegal pulse and leaves all architectural state untouched.

The control is a three-state machine. ST_IDLE means no instruction was accepted on the previous edge. ST_DONE means a multiply was executed on the previous edge, and it drives `done`. ST_ILLEGAL means a non-matching word was rejected on the previous edge, and it drives `illegal`. The transitions are the same from every state. A valid strobe with a matching word goes to ST_DONE. A valid strobe with any other word goes to ST_ILLEGAL. No strobe returns to ST_IDLE. Back-to-back instructions are therefore accepted on every cycle.

A debug port lets a testbench or debugger preload and read back any register and the status register. When an instruction is accepted, its writes take priority over a debug write made in the same cycle.

Top module: `mulu_unit`

## Requirements
- R1: After reset, every register and the status register read 0x00, and `done` and `illegal` are low.
- R2: A word is a multiply when (word AND 0xFC00) equals 0x9C00. A valid strobe with such a word makes `done` high for exactly the following cycle, with `illegal` low.
- R3: The first source number is word bits [8:4]. The second source number is {word bit 9, word bits [3:0]}, so its high bit is not adjacent to its low bits.
- R4: Both operands are unsigned. The 16-bit product has its low byte written to register 0 and its high byte to register 1, whatever the source numbers are. No other register changes.
- R5: The carry flag, status bit 0, is set equal to bit 15 of the product.
- R6: The zero flag, status bit 1, is set when the whole product is 0x0000 and is cleared otherwise.
- R7: Status bits 7..2 keep their previous values across a multiply.
- R8: When both source numbers are equal, the register value is squared.
- R9: Operands are read before the result is written, so source register 0 or 1 gives the product of the values held before the instruction.
- R10: A strobed word that is not a multiply makes `illegal` high for exactly the following cycle, with `done` low, and changes no register and no status bit.
- R11: The debug port writes a register or the status register on its write enable and reads back any register combinationally.
- R12: `done` and `illegal` are never high together, and both are low in a cycle that follows no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word strobe |
| instr_word | input | 16 | Instruction word |
| done | output | 1 | One-cycle pulse after a multiply executes |
| illegal | output | 1 | One-cycle pulse after a word is rejected |
| dbg_reg_we | input | 1 | Debug register write enable |
| dbg_reg_addr | input | 5 | Debug register index |
| dbg_reg_wdata | input | 8 | Debug register write data |
| dbg_reg_rdata | output | 8 | Debug register read data (combinational) |
| dbg_sreg_we | input | 1 | Debug status register write enable |
| dbg_sreg_wdata | input | 8 | Debug status register write data |
| sreg | output | 8 | Status register value |

## Verification
The bench builds the unit with its default parameters: an 8-bit data path, 32 registers, and the 0x9C00/0xFC00 match pattern. With these defaults, every bit of the 5-bit register field can be reached from the word, including the scattered bit 9. The vector table uses register numbers above 15 to exercise that bit. It also uses sources 0 and 1 to show that operands are read before the overwrite, and equal sources to exercise squaring. Status values preloaded with the upper bits set show that those bits survive a multiply, while products of 0x0000, 0xFE01 and 0x9000 reach both flags in both polarities.

// File: rtl/mulu_pkg.sv
package mulu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DONE    = 2'd1,
        ST_ILLEGAL = 2'd2
    } mulu_state_e;

endpackage

// File: rtl/mulu_decode.sv
module mulu_decode #(
    parameter int              IW       = 16,
    parameter int              AW       = 5,
    parameter logic [IW-1:0]   OPC_VAL  = 16'h9C00,
    parameter logic [IW-1:0]   OPC_MASK = 16'hFC00
) (
    input  logic [IW-1:0] word,
    output logic          hit,
    output logic [AW-1:0] d_idx,
    output logic [AW-1:0] r_idx
);
    // Pattern match on the opcode bits only
    assign hit   = ((word & OPC_MASK) == OPC_VAL);
    // First source is contiguous
    assign d_idx = word[AW+3:4];
    // Second source: high bit sits above the first source field
    assign r_idx = {word[AW+4], word[AW-2:0]};
endmodule

// File: rtl/mulu_regfile.sv
module mulu_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 32,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_idx,
    input  logic [AW-1:0] rb_idx,
    output logic [DW-1:0] ra_data,
    output logic [DW-1:0] rb_data,
    input  logic          prod_we,
    input  logic [DW-1:0] prod_lo,
    input  logic [DW-1:0] prod_hi,
    input  logic          dbg_we,
    input  logic [AW-1:0] dbg_addr,
    input  logic [DW-1:0] dbg_wdata,
    output logic [DW-1:0] dbg_rdata
);
    logic [DW-1:0] mem [NREG];

    // Reads are combinational, so operands are taken before the edge that writes
    assign ra_data   = mem[ra_idx];
    assign rb_data   = mem[rb_idx];
    assign dbg_rdata = mem[dbg_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (prod_we) begin
            mem[0] <= prod_lo;
            mem[1] <= prod_hi;
        end else if (dbg_we) begin
            mem[dbg_addr] <= dbg_wdata;
        end
    end
endmodule

// File: rtl/mulu_mult.sv
module mulu_mult #(
    parameter int DW   = 8,
    parameter int SW   = 8,
    parameter int CBIT = 0,
    parameter int ZBIT = 1,
    localparam int PW  = 2 * DW
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [SW-1:0] sreg_in,
    output logic [PW-1:0] prod,
    output logic [SW-1:0] sreg_next
);
    assign prod = PW'(a) * PW'(b);

    always_comb begin
        sreg_next       = sreg_in;
        sreg_next[CBIT] = prod[PW-1];
        sreg_next[ZBIT] = (prod == '0);
    end
endmodule

// File: rtl/mulu_unit.sv
module mulu_unit
    import mulu_pkg::*;
#(
    parameter int            DW       = 8,
    parameter int            NREG     = 32,
    parameter int            IW       = 16,
    parameter int            SW       = 8,
    parameter int            CBIT     = 0,
    parameter int            ZBIT     = 1,
    parameter logic [15:0]   OPC_VAL  = 16'h9C00,
    parameter logic [15:0]   OPC_MASK = 16'hFC00,
    localparam int           AW       = $clog2(NREG),
    localparam int           PW       = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [IW-1:0] instr_word,
    output logic          done,
    output logic          illegal,
    input  logic          dbg_reg_we,
    input  logic [AW-1:0] dbg_reg_addr,
    input  logic [DW-1:0] dbg_reg_wdata,
    output logic [DW-1:0] dbg_reg_rdata,
    input  logic          dbg_sreg_we,
    input  logic [SW-1:0] dbg_sreg_wdata,
    output logic [SW-1:0] sreg
);
    mulu_state_e   state_q, state_d;
    logic          hit;
    logic          accept;
    logic [AW-1:0] d_idx, r_idx;
    logic [DW-1:0] op_a, op_b;
    logic [PW-1:0] prod;
    logic [SW-1:0] sreg_q, sreg_next;

    mulu_decode #(
        .IW(IW), .AW(AW), .OPC_VAL(IW'(OPC_VAL)), .OPC_MASK(IW'(OPC_MASK))
    ) u_dec (
        .word(instr_word), .hit(hit), .d_idx(d_idx), .r_idx(r_idx)
    );

    assign accept = instr_valid && hit;

    mulu_regfile #(.DW(DW), .NREG(NREG), .AW(AW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(d_idx), .rb_idx(r_idx),
        .ra_data(op_a), .rb_data(op_b),
        .prod_we(accept), .prod_lo(prod[DW-1:0]), .prod_hi(prod[PW-1:DW]),
        .dbg_we(dbg_reg_we), .dbg_addr(dbg_reg_addr),
        .dbg_wdata(dbg_reg_wdata), .dbg_rdata(dbg_reg_rdata)
    );

    mulu_mult #(.DW(DW), .SW(SW), .CBIT(CBIT), .ZBIT(ZBIT)) u_mul (
        .a(op_a), .b(op_b), .sreg_in(sreg_q),
        .prod(prod), .sreg_next(sreg_next)
    );

    // Status register: instruction update wins over a debug write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (accept) begin
            sreg_q <= sreg_next;
        end else if (dbg_sreg_we) begin
            sreg_q <= dbg_sreg_wdata;
        end
    end

    assign sreg = sreg_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: identical transitions out of every state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_ILLEGAL: begin
                if (instr_valid) begin
                    state_d = hit ? ST_DONE : ST_ILLEGAL;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs from state
    always_comb begin
        done    = 1'b0;
        illegal = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_DONE:    done    = 1'b1;
            ST_ILLEGAL: illegal = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/mulu_chk.sv
module mulu_chk #(
    parameter int          DW       = 8,
    parameter int          IW       = 16,
    parameter int          SW       = 8,
    parameter int          CBIT     = 0,
    parameter int          ZBIT     = 1,
    parameter logic [15:0] OPC_VAL  = 16'h9C00,
    parameter logic [15:0] OPC_MASK = 16'hFC00
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic [IW-1:0] instr_word,
    input logic          done,
    input logic          illegal,
    input logic          dbg_sreg_we,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic [SW-1:0] sreg
);
    localparam int PW = 2 * DW;
    logic [PW-1:0] ref_prod;
    logic          is_mul;
    logic [SW-1:0] keep_mask;

    assign ref_prod  = PW'(op_a) * PW'(op_b);
    assign is_mul    = ((instr_word & IW'(OPC_MASK)) == IW'(OPC_VAL));
    assign keep_mask = ~((SW'(1) << CBIT) | (SW'(1) << ZBIT));

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && illegal));

    // R2
    mul_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && is_mul) |=> (done && !illegal));

    // R10
    reject_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !is_mul && !dbg_sreg_we) |=> (illegal && !done && $stable(sreg)));

    // R5
    carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && is_mul) |=> (sreg[CBIT] == $past(ref_prod[PW-1])));

    // R6
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && is_mul) |=> (sreg[ZBIT] == ($past(ref_prod) == '0)));

    // R7
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && is_mul) |=> ((sreg & keep_mask) == $past(sreg & keep_mask)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!done && !illegal));
endmodule

bind mulu_unit mulu_chk #(
    .DW(DW), .IW(IW), .SW(SW), .CBIT(CBIT), .ZBIT(ZBIT),
    .OPC_VAL(OPC_VAL), .OPC_MASK(OPC_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_word(instr_word),
    .done(done), .illegal(illegal),
    .dbg_sreg_we(dbg_sreg_we),
    .op_a(op_a), .op_b(op_b), .sreg(sreg)
);

// File: tb/sim_mulu_unit.sv
module sim_mulu_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr_word = '0;
    logic        done, illegal;
    logic        dbg_reg_we = 1'b0;
    logic [4:0]  dbg_reg_addr = '0;
    logic [7:0]  dbg_reg_wdata = '0;
    logic [7:0]  dbg_reg_rdata;
    logic        dbg_sreg_we = 1'b0;
    logic [7:0]  dbg_sreg_wdata = '0;
    logic [7:0]  sreg;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mulu_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_word(instr_word),
        .done(done), .illegal(illegal),
        .dbg_reg_we(dbg_reg_we), .dbg_reg_addr(dbg_reg_addr),
        .dbg_reg_wdata(dbg_reg_wdata), .dbg_reg_rdata(dbg_reg_rdata),
        .dbg_sreg_we(dbg_sreg_we), .dbg_sreg_wdata(dbg_sreg_wdata),
        .sreg(sreg)
    );

    // {d[4:0], r[4:0], value_d[7:0], value_r[7:0]}
    localparam int NV = 13;
    localparam logic [25:0] VEC [NV] = '{
        {5'd8,  5'd9,  8'h00, 8'h00},
        {5'd16, 5'd17, 8'h01, 8'h00},
        {5'd24, 5'd25, 8'h00, 8'h4D},
        {5'd8,  5'd17, 8'hFF, 8'hFF},
        {5'd16, 5'd25, 8'hFF, 8'h4D},
        {5'd24, 5'd1,  8'h01, 8'hFF},
        {5'd0,  5'd9,  8'hFF, 8'hFF},
        {5'd9,  5'd1,  8'h80, 8'h02},
        {5'd5,  5'd5,  8'hFF, 8'h00},
        {5'd0,  5'd1,  8'h10, 8'h20},
        {5'd1,  5'd1,  8'hC0, 8'h00},
        {5'd31, 5'd30, 8'h80, 8'h80},
        {5'd16, 5'd31, 8'hFF, 8'h80}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk);
        dbg_reg_we = 1'b1; dbg_reg_addr = a; dbg_reg_wdata = v;
        @(negedge clk);
        dbg_reg_we = 1'b0;
    endtask

    task automatic sreg_wr(input logic [7:0] v);
        @(negedge clk);
        dbg_sreg_we = 1'b1; dbg_sreg_wdata = v;
        @(negedge clk);
        dbg_sreg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [4:0] a, output logic [7:0] v);
        dbg_reg_addr = a;
        #1;
        v = dbg_reg_rdata;
    endtask

    function automatic logic [15:0] enc(input logic [4:0] d, input logic [4:0] r);
        return 16'h9C00 | 16'(r[3:0]) | (16'(d) << 4) | (16'(r[4]) << 9);
    endfunction

    // Strobe one word; returns at the negedge after the accepting edge
    task automatic issue(input logic [15:0] w);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] v0, v1, vx;
        #(8 * 200000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] r0v, r1v, rv, pre;
        logic [4:0] d, r;
        logic [7:0] vd, vr;
        logic [15:0] p, exp_s;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done", 16'(done), 16'h0);
        check("R1 illegal", 16'(illegal), 16'h0);
        check("R1 sreg", 16'(sreg), 16'h0);
        reg_rd(5'd0, rv);  check("R1 reg0", 16'(rv), 16'h0);
        reg_rd(5'd31, rv); check("R1 reg31", 16'(rv), 16'h0);
        rst_n = 1'b1;

        // R11: debug write and read back
        reg_wr(5'd20, 8'h5A);
        reg_rd(5'd20, rv); check("R11 reg20", 16'(rv), 16'h5A);
        sreg_wr(8'h3C);
        check("R11 sreg", 16'(sreg), 16'h3C);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            {d, r, vd, vr} = VEC[i];
            if (d == r) vr = vd;
            pre = (i % 2 == 0) ? 8'hA4 : 8'h5B;
            reg_wr(d, vd);
            if (d != r) reg_wr(r, vr);
            sreg_wr(pre);
            p = 16'(vd) * 16'(vr);
            exp_s = 16'((pre & 8'hFC) | (8'(p == 16'h0) << 1) | 8'(p[15]));
            issue(enc(d, r));
            check("R2 done", {15'h0, done}, 16'h1);
            check("R2 illegal low", {15'h0, illegal}, 16'h0);
            reg_rd(5'd0, r0v); reg_rd(5'd1, r1v);
            check("R4 R8 R9 product", {r1v, r0v}, p);
            check("R5 R6 R7 sreg", 16'(sreg), exp_s);
            reg_rd(5'd20, rv); check("R4 bystander", 16'(rv), 16'h5A);
            @(negedge clk);
            check("R12 done falls", {15'h0, done}, 16'h0);
        end

        // R10: rejected words leave state alone
        reg_wr(5'd0, 8'h11);
        reg_wr(5'd1, 8'h22);
        sreg_wr(8'h37);
        foreach (VEC[k]) begin end
        issue(16'h9800);
        check("R10 illegal", {15'h0, illegal}, 16'h1);
        check("R10 done low", {15'h0, done}, 16'h0);
        check("R10 sreg", 16'(sreg), 16'h37);
        reg_rd(5'd0, r0v); reg_rd(5'd1, r1v);
        check("R10 regs", {r1v, r0v}, 16'h2211);
        issue(16'hFC00 | 16'h0011);
        check("R10 illegal top", {15'h0, illegal}, 16'h1);
        reg_rd(5'd0, r0v); reg_rd(5'd1, r1v);
        check("R10 regs top", {r1v, r0v}, 16'h2211);
        check("R10 sreg top", 16'(sreg), 16'h37);
        @(negedge clk);
        check("R12 illegal falls", {15'h0, illegal}, 16'h0);

        // R3: all-ones word selects d=31, r=31 (bit 9 high)
        reg_wr(5'd31, 8'h03);
        issue(16'h9FFF);
        reg_rd(5'd0, r0v); reg_rd(5'd1, r1v);
        check("R3 R8 word 9FFF", {r1v, r0v}, 16'h0009);

        // R2 R12: back-to-back strobes, second illegal
        @(negedge clk);
        instr_valid = 1'b1; instr_word = enc(5'd20, 5'd31);
        @(negedge clk);
        check("R2 back-to-back done", {15'h0, done}, 16'h1);
        instr_word = 16'h0000;
        @(negedge clk);
        instr_valid = 1'b0;
        check("R12 second illegal", {14'h0, done, illegal}, 16'h1);
        reg_rd(5'd0, r0v); reg_rd(5'd1, r1v);
        check("R4 back-to-back product", {r1v, r0v}, 16'h010E);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule